// File: doc/BRIEF.md
# Holding-Register Multi-Byte Transfer Engine

This block sits between a register bus and the two byte-wide FIFOs of a serial port. It turns bus accesses to the transmit and receive holding registers into FIFO pushes and pops. A write always targets the transmit side and a read always targets the receive side. The access size and the port's operating mode together decide how many bytes one access moves.

The operating mode is derived from the frame and protocol settings, with no setting of its own. The port runs in single-data mode when 9-bit characters are enabled, or when the protocol selector picks LIN master, LIN slave or the single-datum network mode. In any other case it runs in multiple-data mode. In multiple-data mode a 32-bit access moves up to four bytes, one per cycle, packed little-endian. An 8-bit access, and any access in single-data mode, moves one byte.

A sequencer controls each access through four named states. ST_IDLE takes a request and goes to ST_PUSH on a write or to ST_POP on a read. ST_PUSH and ST_POP each move one byte per cycle. They go to ST_RESP after the last byte, when the transmit FIFO is full, or when the receive FIFO is empty. ST_RESP raises the one-cycle acknowledge and then returns to ST_IDLE.

Top module: `hold_reg_xfer`

## Requirements
- R1: The port is in multiple-data mode only when `cfg_nine_bit` is 0 and `cfg_proto` is 0. Any other setting selects single-data mode, and the other `cfg_proto` codes are 1 for LIN master, 2 for LIN slave and 3 for the single-datum network mode.
- R2: An 8-bit write (`bus_word`=0) pushes exactly one byte, `bus_wdata[7:0]`, in either mode.
- R3: An 8-bit read pops at most one byte and returns it in `bus_rdata[7:0]`, with bits [31:8] at zero, in either mode.
- R4: In single-data mode a 32-bit access moves exactly one byte, through lane [7:0].
- R5: In multiple-data mode a 32-bit write pushes four bytes on consecutive cycles, starting with bits [7:0] and ending with bits [31:24].
- R6: In multiple-data mode a 32-bit read pops up to four bytes. The first byte popped lands in bits [7:0], the next in bits [15:8], and so on.
- R7: A read pops only the bytes that are present and returns zero in every lane it did not fill. A read of an empty FIFO pops nothing and returns zero.
- R8: A write pushes bytes in order until the transmit FIFO is full and drops the rest. It signals `bus_err` together with `bus_ack` if any byte was dropped. A push is never issued while `tx_full` is high.
- R9: `tx_ready` equals the inverse of `tx_full` and `rx_ready` equals the inverse of `rx_empty`, in every cycle.
- R10: Every access ends with `bus_ack` high for exactly one cycle. A request raised while `bus_busy` is high is ignored.
- R11: During and right after reset, `bus_ack`, `bus_err`, `bus_busy`, `tx_push` and `rx_pop` are 0 and `bus_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_nine_bit | input | 1 | 9-bit character format enabled |
| cfg_proto | input | 2 | Protocol selector: 0 plain, 1 LIN master, 2 LIN slave, 3 single-datum network |
| bus_req | input | 1 | Access request, accepted in ST_IDLE |
| bus_we | input | 1 | 1 = write to the transmit holding register, 0 = read from the receive holding register |
| bus_word | input | 1 | 1 = 32-bit access, 0 = 8-bit access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_ack |
| bus_ack | output | 1 | One-cycle completion strobe |
| bus_err | output | 1 | Overflow on the completed write, valid with bus_ack |
| bus_busy | output | 1 | An access is in progress |
| tx_push | output | 1 | Push strobe to the transmit FIFO |
| tx_data | output | 8 | Byte pushed |
| tx_full | input | 1 | Transmit FIFO is full |
| tx_ready | output | 1 | At least one transmit entry is free |
| rx_pop | output | 1 | Pop strobe to the receive FIFO |
| rx_data | input | 8 | Head byte of the receive FIFO (show-ahead) |
| rx_empty | input | 1 | Receive FIFO is empty |
| rx_ready | output | 1 | At least one received byte is available |

## Verification
The bench checks the byte order of 32-bit transfers in both directions. A swapped lane order would push or return bytes reversed. It sends 32-bit accesses under every protocol code and with 9-bit characters enabled. A wrong mode decoder would move four bytes where one is expected, and the scoreboard would report an unexpected push or an overdrawn receive count. It reads from a FIFO holding fewer than four bytes and from an empty one. A design that ignores the empty flag would pop phantom bytes or leave stale data in the upper lanes. It also writes into a transmit FIFO that fills partway through a word, and raises a request while an access is still in progress. A design that pushes while full, or that starts a second access, would show extra pushes or a missing error.

// File: rtl/hrx_pkg.sv
package hrx_pkg;

    // Protocol selector codes; only PROTO_PLAIN allows multi-byte access
    typedef enum logic [1:0] {
        PROTO_PLAIN      = 2'd0,
        PROTO_LIN_MST    = 2'd1,
        PROTO_LIN_SLV    = 2'd2,
        PROTO_NET_SINGLE = 2'd3
    } proto_e;

    // Access sequencer states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PUSH = 2'd1,
        ST_POP  = 2'd2,
        ST_RESP = 2'd3
    } xfer_st_e;

endpackage

// File: rtl/hrx_mode_sel.sv
module hrx_mode_sel
    import hrx_pkg::*;
(
    input  logic       nine_bit,
    input  logic [1:0] proto,
    output logic       multi
);

    proto_e proto_v;

    always_comb begin
        proto_v = proto_e'(proto);
        // R1: any 9-bit framing or non-plain protocol forces one datum per access
        multi   = !nine_bit && (proto_v == PROTO_PLAIN);
    end

endmodule

// File: rtl/hrx_seq.sv
module hrx_seq
    import hrx_pkg::*;
#(
    parameter  int LANES = 4,
    localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             we,
    input  logic             word,
    input  logic             multi,
    input  logic             tx_full,
    input  logic             rx_empty,
    output logic [IDX_W-1:0] idx,
    output logic             push,
    output logic             pop,
    output logic             load,
    output logic             clr,
    output logic             ack,
    output logic             busy,
    output logic             err
);

    xfer_st_e         st_q;
    xfer_st_e         st_nx;
    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] last_q;
    logic             err_q;
    logic             accept;
    logic             at_last;

    assign accept  = (st_q == ST_IDLE) && req;
    assign at_last = (idx_q == last_q);

    // State register and per-access counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            idx_q  <= '0;
            last_q <= '0;
            err_q  <= 1'b0;
        end else begin
            st_q <= st_nx;
            if (accept) begin
                idx_q  <= '0;
                last_q <= (word && multi) ? IDX_W'(LANES - 1) : '0;
                err_q  <= 1'b0;
            end else if (st_q == ST_PUSH) begin
                if (tx_full)
                    err_q <= 1'b1;
                else if (!at_last)
                    idx_q <= idx_q + 1'b1;
            end else if (st_q == ST_POP) begin
                if (!rx_empty && !at_last)
                    idx_q <= idx_q + 1'b1;
            end
        end
    end

    // Next-state decision
    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            ST_IDLE: if (req) st_nx = we ? ST_PUSH : ST_POP;
            ST_PUSH: if (tx_full || at_last) st_nx = ST_RESP;
            ST_POP:  if (rx_empty || at_last) st_nx = ST_RESP;
            ST_RESP: st_nx = ST_IDLE;
            default: st_nx = ST_IDLE;
        endcase
    end

    // Outputs decoded from the state register
    always_comb begin
        push = 1'b0;
        pop  = 1'b0;
        ack  = 1'b0;
        unique case (st_q)
            ST_IDLE: ;
            ST_PUSH: push = !tx_full;
            ST_POP:  pop  = !rx_empty;
            ST_RESP: ack  = 1'b1;
            default: ;
        endcase
        load = accept && we;
        clr  = accept && !we;
        busy = (st_q != ST_IDLE);
        err  = ack && err_q;
        idx  = idx_q;
    end

endmodule

// File: rtl/hrx_lanes.sv
module hrx_lanes #(
    parameter  int DATA_W = 8,
    parameter  int LANES  = 4,
    localparam int BUS_W  = DATA_W * LANES,
    localparam int IDX_W  = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              clr,
    input  logic              cap,
    input  logic [IDX_W-1:0]  idx,
    input  logic [BUS_W-1:0]  wdata,
    input  logic [DATA_W-1:0] rd_byte,
    output logic [BUS_W-1:0]  word_q,
    output logic [DATA_W-1:0] sel_byte
);

    // One register per byte lane; shared by write staging and read assembly
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [DATA_W-1:0] lane_r;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                lane_r <= '0;
            else if (load)
                lane_r <= wdata[g*DATA_W +: DATA_W];
            else if (clr)
                lane_r <= '0;
            else if (cap && (idx == IDX_W'(g)))
                lane_r <= rd_byte;
        end

        assign word_q[g*DATA_W +: DATA_W] = lane_r;
    end

    assign sel_byte = word_q[idx*DATA_W +: DATA_W];

endmodule

// File: rtl/hold_reg_xfer.sv
module hold_reg_xfer #(
    parameter  int DATA_W = 8,
    parameter  int LANES  = 4,
    localparam int BUS_W  = DATA_W * LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_nine_bit,
    input  logic [1:0]        cfg_proto,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic              bus_word,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              bus_ack,
    output logic              bus_err,
    output logic              bus_busy,
    output logic              tx_push,
    output logic [DATA_W-1:0] tx_data,
    input  logic              tx_full,
    output logic              tx_ready,
    output logic              rx_pop,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_empty,
    output logic              rx_ready
);

    localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1;

    logic             multi_mode;
    logic [IDX_W-1:0] lane_idx;
    logic             lane_load;
    logic             lane_clr;

    hrx_mode_sel u_mode (
        .nine_bit (cfg_nine_bit),
        .proto    (cfg_proto),
        .multi    (multi_mode)
    );

    hrx_seq #(.LANES(LANES)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (bus_req),
        .we       (bus_we),
        .word     (bus_word),
        .multi    (multi_mode),
        .tx_full  (tx_full),
        .rx_empty (rx_empty),
        .idx      (lane_idx),
        .push     (tx_push),
        .pop      (rx_pop),
        .load     (lane_load),
        .clr      (lane_clr),
        .ack      (bus_ack),
        .busy     (bus_busy),
        .err      (bus_err)
    );

    hrx_lanes #(.DATA_W(DATA_W), .LANES(LANES)) u_lanes (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (lane_load),
        .clr      (lane_clr),
        .cap      (rx_pop),
        .idx      (lane_idx),
        .wdata    (bus_wdata),
        .rd_byte  (rx_data),
        .word_q   (bus_rdata),
        .sel_byte (tx_data)
    );

    // R9: level status toward the bus side
    assign tx_ready = !tx_full;
    assign rx_ready = !rx_empty;

endmodule

// File: rtl/hold_reg_xfer_chk.sv
module hold_reg_xfer_chk #(
    parameter int LANES = 4
) (
    input logic clk,
    input logic rst_n,
    input logic multi_mode,
    input logic bus_req,
    input logic bus_word,
    input logic bus_ack,
    input logic bus_err,
    input logic bus_busy,
    input logic tx_push,
    input logic tx_full,
    input logic rx_pop,
    input logic rx_empty
);

    localparam int CNT_W = $clog2(LANES + 2) + 1;

    logic             wide_q;
    logic [CNT_W-1:0] xfer_cnt;

    // Track how many bytes the current access has moved
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wide_q   <= 1'b0;
            xfer_cnt <= '0;
        end else if (bus_req && !bus_busy) begin
            wide_q   <= bus_word && multi_mode;
            xfer_cnt <= '0;
        end else if (tx_push || rx_pop) begin
            xfer_cnt <= xfer_cnt + 1'b1;
        end
    end

    // R2 R3 R4: narrow or single-data accesses move at most one byte
    a_r4_one_datum: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack && !wide_q |-> xfer_cnt <= CNT_W'(1));

    // R5 R6: a wide access never moves more than one byte per lane
    a_r6_lane_limit: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_cnt <= CNT_W'(LANES));

    a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        tx_push |-> !tx_full);

    a_r7_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop |-> !rx_empty);

    a_r10_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |=> !bus_ack);

    a_r8_err_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> bus_ack);

    a_r10_one_side: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_push && rx_pop));

endmodule

bind hold_reg_xfer hold_reg_xfer_chk #(.LANES(LANES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .multi_mode (multi_mode),
    .bus_req    (bus_req),
    .bus_word   (bus_word),
    .bus_ack    (bus_ack),
    .bus_err    (bus_err),
    .bus_busy   (bus_busy),
    .tx_push    (tx_push),
    .tx_full    (tx_full),
    .rx_pop     (rx_pop),
    .rx_empty   (rx_empty)
);

// File: tb/hold_reg_xfer_tb_top.sv
`timescale 1ns/1ps
module hold_reg_xfer_tb_top;

    localparam int TX_DEPTH = 6;

    typedef struct {
        logic        is_rd;
        logic [31:0] rdata;
        logic        err;
        string       tag;
    } resp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_nine_bit = 1'b0;
    logic [1:0]  cfg_proto = 2'd0;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic        bus_word = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_ack, bus_err, bus_busy;
    logic        tx_push, tx_full, tx_ready;
    logic [7:0]  tx_data;
    logic        rx_pop, rx_empty, rx_ready;
    logic [7:0]  rx_data;

    // Bench FIFO models
    logic [4:0]  tx_cnt;
    logic        tx_drain = 1'b0;
    logic [7:0]  rxm [16];
    logic [3:0]  rx_rd, rx_wr;
    logic [4:0]  rx_cnt;
    logic        fill_en = 1'b0;
    logic [7:0]  fill_byte = '0;

    int    checks = 0;
    int    errors = 0;
    string cur_tag = "";
    logic [7:0] exp_tx [$];
    resp_t      exp_resp [$];

    always #2 clk = ~clk;

    hold_reg_xfer dut_i (
        .clk, .rst_n, .cfg_nine_bit, .cfg_proto,
        .bus_req, .bus_we, .bus_word, .bus_wdata,
        .bus_rdata, .bus_ack, .bus_err, .bus_busy,
        .tx_push, .tx_data, .tx_full, .tx_ready,
        .rx_pop, .rx_data, .rx_empty, .rx_ready
    );

    assign tx_full  = (tx_cnt == 5'(TX_DEPTH));
    assign rx_data  = rxm[rx_rd];
    assign rx_empty = (rx_cnt == 5'd0);

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_cnt <= '0;
        end else if (tx_drain) begin
            tx_cnt <= '0;
        end else if (tx_push && !tx_full) begin
            tx_cnt <= tx_cnt + 5'd1;
        end
    end

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_rd  <= '0;
            rx_wr  <= '0;
            rx_cnt <= '0;
        end else begin
            if (fill_en) begin
                rxm[rx_wr] <= fill_byte;
                rx_wr      <= rx_wr + 4'd1;
            end
            if (rx_pop && !rx_empty) rx_rd <= rx_rd + 4'd1;
            rx_cnt <= rx_cnt + 5'(fill_en) - 5'(rx_pop && !rx_empty);
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Scoreboard monitor: compares pushes and responses as they appear
    always @(negedge clk) begin
        if (rst_n && tx_push) begin
            if (exp_tx.size() == 0) begin
                checks++; errors++;
                $display("FAIL %s unexpected push act=%h exp=none", cur_tag, tx_data);
            end else begin
                chk({cur_tag, " push byte"}, 32'(tx_data), 32'(exp_tx.pop_front()));
            end
        end
        if (rst_n && bus_ack) begin
            if (exp_resp.size() == 0) begin
                checks++; errors++;
                $display("FAIL R10 unexpected ack act=1 exp=0");
            end else begin
                resp_t r;
                r = exp_resp.pop_front();
                if (r.is_rd) chk({r.tag, " rdata"}, bus_rdata, r.rdata);
                chk({r.tag, " err"}, 32'(bus_err), 32'(r.err));
            end
        end
    end

    task automatic drain_tx();
        tx_drain = 1'b1;
        @(negedge clk);
        tx_drain = 1'b0;
    endtask

    task automatic fill_rx(input logic [7:0] b);
        fill_en   = 1'b1;
        fill_byte = b;
        @(negedge clk);
        fill_en   = 1'b0;
    endtask

    // Driver: computes the expected outcome from the requirements, then runs the access
    task automatic access(input logic we, input logic word, input logic [31:0] wd,
                          input logic poke, input string tag);
        int    n, np, k;
        logic  multi_b;
        logic [31:0] e;
        logic [4:0]  tx_after, rx_after;
        resp_t r;
        cur_tag  = tag;
        multi_b  = !cfg_nine_bit && (cfg_proto == 2'd0);
        n        = (word && multi_b) ? 4 : 1;
        tx_after = tx_cnt;
        rx_after = rx_cnt;
        if (we) begin
            np = TX_DEPTH - int'(tx_cnt);
            if (np > n) np = n;
            for (int i = 0; i < np; i++) exp_tx.push_back(wd[8*i +: 8]);
            tx_after = tx_cnt + 5'(np);
            r = '{1'b0, 32'd0, (np < n), tag};
        end else begin
            np = int'(rx_cnt);
            if (np > n) np = n;
            e = '0;
            for (int i = 0; i < np; i++) e[8*i +: 8] = rxm[rx_rd + 4'(i)];
            rx_after = rx_cnt - 5'(np);
            r = '{1'b1, e, 1'b0, tag};
        end
        exp_resp.push_back(r);
        bus_req   = 1'b1;
        bus_we    = we;
        bus_word  = word;
        bus_wdata = wd;
        @(negedge clk);
        bus_req = 1'b0;
        if (poke) begin
            // R10: a second request while busy must be ignored
            bus_req   = 1'b1;
            bus_we    = 1'b1;
            bus_word  = 1'b1;
            bus_wdata = ~wd;
            @(negedge clk);
            bus_req = 1'b0;
        end
        k = 0;
        while (!bus_ack && k < 20) begin
            @(negedge clk);
            k++;
        end
        @(negedge clk);
        chk({tag, " R10 ack single cycle"}, 32'(bus_ack), 32'd0);
        chk({tag, " R10 idle after ack"}, 32'(bus_busy), 32'd0);
        chk({tag, " pushes outstanding"}, exp_tx.size(), 32'd0);
        chk({tag, " tx count"}, 32'(tx_cnt), 32'(tx_after));
        chk({tag, " rx count"}, 32'(rx_cnt), 32'(rx_after));
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL R10 watchdog act=running exp=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11 ack in reset", 32'(bus_ack), 32'd0);
        chk("R11 push in reset", 32'(tx_push), 32'd0);
        chk("R11 pop in reset", 32'(rx_pop), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 rdata after reset", bus_rdata, 32'd0);
        chk("R11 busy after reset", 32'(bus_busy), 32'd0);
        chk("R11 err after reset", 32'(bus_err), 32'd0);
        chk("R9 tx_ready empty fifo", 32'(tx_ready), 32'd1);
        chk("R9 rx_ready empty fifo", 32'(rx_ready), 32'd0);

        // Multiple-data mode (R1 plain protocol)
        access(1'b1, 1'b0, 32'hFFFF_FFA5, 1'b0, "R2 byte write");
        access(1'b1, 1'b1, 32'h4433_2211, 1'b0, "R5 word write");
        drain_tx();
        for (int i = 1; i <= 5; i++) fill_rx(8'(8'h10 * i + i));
        chk("R9 rx_ready with data", 32'(rx_ready), 32'd1);
        access(1'b0, 1'b1, '0, 1'b0, "R6 word read");
        access(1'b0, 1'b0, '0, 1'b0, "R3 byte read");
        access(1'b0, 1'b1, '0, 1'b0, "R7 empty read");
        fill_rx(8'hC1);
        fill_rx(8'hC2);
        access(1'b0, 1'b1, '0, 1'b0, "R7 short read");
        fill_rx(8'hE7);
        fill_rx(8'hE8);
        access(1'b0, 1'b0, '0, 1'b0, "R3 byte read keeps rest");
        access(1'b0, 1'b0, '0, 1'b0, "R3 byte read last");

        // Overflow handling
        access(1'b1, 1'b1, 32'h0403_0201, 1'b0, "R8 fill four");
        access(1'b1, 1'b1, 32'hDDCC_BBAA, 1'b0, "R8 partial push");
        chk("R9 tx_ready when full", 32'(tx_ready), 32'd0);
        access(1'b1, 1'b0, 32'h0000_0077, 1'b0, "R8 byte into full");
        drain_tx();

        // Request while busy
        access(1'b1, 1'b1, 32'h8765_4321, 1'b1, "R10 busy request");
        drain_tx();

        // Single-data mode: 9-bit characters
        cfg_nine_bit = 1'b1;
        access(1'b1, 1'b1, 32'h1234_5699, 1'b0, "R4 R1 nine-bit word write");
        fill_rx(8'h5A);
        fill_rx(8'h5B);
        access(1'b0, 1'b1, '0, 1'b0, "R4 R1 nine-bit word read");
        access(1'b0, 1'b1, '0, 1'b0, "R4 R1 nine-bit drain");
        cfg_nine_bit = 1'b0;
        drain_tx();

        // Single-data mode: each non-plain protocol code
        for (int p = 1; p <= 3; p++) begin
            cfg_proto = 2'(p);
            fill_rx(8'(8'h60 + p));
            fill_rx(8'(8'h70 + p));
            access(1'b0, 1'b1, '0, 1'b0, "R1 protocol word read");
            access(1'b1, 1'b1, 32'hA0B0_C0D0, 1'b0, "R1 protocol word write");
            access(1'b0, 1'b1, '0, 1'b0, "R1 protocol second read");
            drain_tx();
        end
        cfg_proto = 2'd0;
        access(1'b1, 1'b1, 32'h5566_7788, 1'b0, "R1 back to multiple");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule